// File: doc/BRIEF.md
# CAN Fault Confinement Error Counters

This block holds the transmit error count (TEC) and the receive error count (REC) of a CAN node, and from them derives the node's fault confinement state. The protocol engine drives it with single-cycle event strobes. Each strobe reports one thing: an error seen as receiver, an error flag sent as transmitter, a bit error while the node drives an active error or overload flag, an over-long dominant run, or a frame completed cleanly. The engine also raises a strobe on the first bit of the error delimiter.

Error events are not applied when they arrive. Each one adds a weight (1 or 8) to a pending sum for its counter, and the whole pending sum is committed in a single update on the delimiter strobe. Two qualifier inputs cancel the transmitter's error-flag increment in the exception cases. A clean transmission or reception decrements the matching counter at once. Once the receive side has saturated, it is marked passive by a separate flag. A clean reception in that condition reloads REC to 119 rather than counting it down.

A TEC overflow puts the node in bus-off. TEC then freezes at 255 until the asynchronous reset clears the block.

Top module: `can_fc_top`

## Requirements
- R1: After reset, TEC and REC are 0, the receive-passive flag is clear, and only the error-active status is high.
- R2: Error events do not change either counter until the delimiter strobe. On the delimiter strobe the pending sums, including events strobed in that same cycle, are applied and then cleared.
- R3: REC increments are as follows. A receive error adds 1; it is ignored in a cycle where the flag-bit-error strobe is also high. A dominant bit after the error flag adds 8. A flag bit error with the transmitter tag low adds 8. A dominant run with the transmitter tag low adds 8.
- R4: TEC increments are as follows. An error flag sent adds 8. A flag bit error with the transmitter tag high adds 8. A dominant run with the transmitter tag high adds 8.
- R5: An error-flag-sent strobe adds nothing to TEC when either exception qualifier (passive ACK error with no dominant bit seen, or arbitration stuff error) is high in the same cycle.
- R6: Several error events gathered before one delimiter strobe are summed and applied as one update.
- R7: A clean-transmission strobe lowers TEC by 1 in the next cycle. TEC stays at 0 if it is already 0.
- R8: A clean-reception strobe lowers REC by 1 when REC is between 1 and 127 and the passive flag is clear. REC stays at 0 if it is already 0.
- R9: When a committed sum would take REC above 127, REC becomes 127 and the receive-passive flag is set.
- R10: A clean-reception strobe while the passive flag is set loads REC with 119 and clears the flag.
- R11: Outside bus-off, error-passive is high when TEC is at least 128 or the passive flag is set. Otherwise error-active is high. Exactly one of the three status outputs is high.
- R12: A commit that would take TEC above 255 sets TEC to 255 and enters bus-off. TEC and bus-off then stay unchanged until reset. A commit that reaches exactly 255 does not enter bus-off.
- R13: A clean-transmission or clean-reception strobe in the same cycle as the delimiter strobe is dropped. Only the commit takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_err_i | input | 1 | Receiver detected an error |
| rx_dom_after_flag_i | input | 1 | Receiver saw dominant bit right after its error flag |
| tx_flag_sent_i | input | 1 | Transmitter sent an error flag |
| ack_exc_i | input | 1 | Qualifier: passive ACK error, no dominant bit during passive flag |
| stuff_exc_i | input | 1 | Qualifier: arbitration stuff error on a recessive stuff bit |
| flag_bit_err_i | input | 1 | Bit error while driving an active error or overload flag |
| flag_bit_err_tx_i | input | 1 | Tag for flag_bit_err_i: 1 transmitter, 0 receiver |
| dom_run_i | input | 1 | Over-long dominant run detected (14 then each 8, or 8 after passive flag) |
| dom_run_tx_i | input | 1 | Tag for dom_run_i: 1 transmitter, 0 receiver |
| tx_ok_i | input | 1 | Frame transmitted without error |
| rx_ok_i | input | 1 | Frame received without error |
| delim_i | input | 1 | First bit of the error delimiter: commit pending increments |
| tec_o | output | 8 | Transmit error count |
| rec_o | output | 7 | Receive error count |
| rec_passive_o | output | 1 | Receive-passive flag |
| err_active_o | output | 1 | Node is error-active |
| err_passive_o | output | 1 | Node is error-passive |
| bus_off_o | output | 1 | Node is bus-off |

## Verification
All outputs come from registers. A decrement strobe, or a delimiter strobe together with the events pending before it, shows on the outputs right after the clock edge that samples it. An error strobe without the delimiter leaves the outputs unchanged. Inputs are driven on the falling edge. The reference model steps on each rising edge, and every output is compared one nanosecond after that edge, so each comparison sees the result of the edge just taken. The directed checks sample on the falling edge after a strobe's rising edge, which is the first place its result is due.

// File: rtl/can_fc_pkg.sv
package can_fc_pkg;
  localparam int unsigned WEIGHT_MINOR = 1;
  localparam int unsigned WEIGHT_MAJOR = 8;

  typedef enum logic [1:0] {
    FC_ACTIVE  = 2'd0,
    FC_PASSIVE = 2'd1,
    FC_BUSOFF  = 2'd2
  } fc_state_e;
endpackage

// File: rtl/can_fc_accum.sv
// Pending increment sum, cleared on commit.
module can_fc_accum #(
  parameter int unsigned PEND_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [PEND_W-1:0] step_i,
  input  logic              commit_i,
  output logic [PEND_W-1:0] total_o
);
  logic [PEND_W-1:0] pend_q;
  logic [PEND_W:0]   sum;

  always_comb begin
    sum     = {1'b0, pend_q} + {1'b0, step_i};
    total_o = sum[PEND_W] ? '1 : sum[PEND_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       pend_q <= '0;
    else if (commit_i) pend_q <= '0;
    else               pend_q <= total_o;
  end

  // R2: pending sum only grows between commits
  assert_pend_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit_i |=> pend_q >= $past(pend_q));
endmodule

// File: rtl/can_fc_tec.sv
module can_fc_tec #(
  parameter int unsigned TEC_W  = 8,
  parameter int unsigned PEND_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              commit_i,
  input  logic [PEND_W-1:0] inc_i,
  input  logic              ok_i,
  output logic [TEC_W-1:0]  tec_o,
  output logic              bus_off_o
);
  localparam logic [PEND_W:0] MAXV = (PEND_W+1)'((2 ** TEC_W) - 1);

  logic [TEC_W-1:0] tec_q;
  logic             bo_q;
  logic [PEND_W:0]  sum;

  assign sum = (PEND_W+1)'(tec_q) + (PEND_W+1)'(inc_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tec_q <= '0;
      bo_q  <= 1'b0;
    end else if (!bo_q) begin
      if (commit_i) begin
        if (sum > MAXV) begin
          tec_q <= '1;
          bo_q  <= 1'b1;
        end else begin
          tec_q <= sum[TEC_W-1:0];
        end
      end else if (ok_i && tec_q != '0) begin
        tec_q <= tec_q - 1'b1;
      end
    end
  end

  assign tec_o     = tec_q;
  assign bus_off_o = bo_q;

  assert_busoff_frozen_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bo_q |=> bo_q && $stable(tec_q));
  assert_tx_ok_dec_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bo_q && !commit_i && ok_i && tec_q != '0) |=> tec_q == $past(tec_q) - 1'b1);
endmodule

// File: rtl/can_fc_rec.sv
module can_fc_rec #(
  parameter int unsigned REC_W  = 7,
  parameter int unsigned PEND_W = 10,
  parameter int unsigned RELOAD = 119
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              commit_i,
  input  logic [PEND_W-1:0] inc_i,
  input  logic              ok_i,
  output logic [REC_W-1:0]  rec_o,
  output logic              passive_o
);
  localparam logic [PEND_W:0]  MAXV    = (PEND_W+1)'((2 ** REC_W) - 1);
  localparam logic [REC_W-1:0] RELOADV = REC_W'(RELOAD);

  logic [REC_W-1:0] rec_q;
  logic             pas_q;
  logic [PEND_W:0]  sum;

  assign sum = (PEND_W+1)'(rec_q) + (PEND_W+1)'(inc_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rec_q <= '0;
      pas_q <= 1'b0;
    end else if (commit_i) begin
      if (sum > MAXV) begin
        rec_q <= '1;
        pas_q <= 1'b1;
      end else begin
        rec_q <= sum[REC_W-1:0];
      end
    end else if (ok_i) begin
      if (pas_q) begin
        rec_q <= RELOADV;
        pas_q <= 1'b0;
      end else if (rec_q != '0) begin
        rec_q <= rec_q - 1'b1;
      end
    end
  end

  assign rec_o     = rec_q;
  assign passive_o = pas_q;

  assert_passive_at_max_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pas_q |-> rec_q == '1);
  assert_reload_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pas_q && ok_i && !commit_i) |=> (rec_q == RELOADV) && !pas_q);
endmodule

// File: rtl/can_fc_top.sv
module can_fc_top
  import can_fc_pkg::*;
#(
  parameter int unsigned TEC_W      = 8,
  parameter int unsigned REC_W      = 7,
  parameter int unsigned REC_RELOAD = 119
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rx_err_i,
  input  logic             rx_dom_after_flag_i,
  input  logic             tx_flag_sent_i,
  input  logic             ack_exc_i,
  input  logic             stuff_exc_i,
  input  logic             flag_bit_err_i,
  input  logic             flag_bit_err_tx_i,
  input  logic             dom_run_i,
  input  logic             dom_run_tx_i,
  input  logic             tx_ok_i,
  input  logic             rx_ok_i,
  input  logic             delim_i,
  output logic [TEC_W-1:0] tec_o,
  output logic [REC_W-1:0] rec_o,
  output logic             rec_passive_o,
  output logic             err_active_o,
  output logic             err_passive_o,
  output logic             bus_off_o
);
  localparam int unsigned      PEND_W  = TEC_W + 2;
  localparam logic [PEND_W-1:0] W_MIN  = PEND_W'(WEIGHT_MINOR);
  localparam logic [PEND_W-1:0] W_MAJ  = PEND_W'(WEIGHT_MAJOR);
  localparam logic [TEC_W-1:0]  TEC_PAS = {1'b1, {(TEC_W-1){1'b0}}};

  logic [PEND_W-1:0] tec_step, rec_step, tec_tot, rec_tot;
  logic              flag_counts;
  logic              bo;
  fc_state_e         st;

  assign flag_counts = tx_flag_sent_i && !ack_exc_i && !stuff_exc_i;

  always_comb begin
    tec_step = (flag_counts ? W_MAJ : '0)
             + ((flag_bit_err_i && flag_bit_err_tx_i) ? W_MAJ : '0)
             + ((dom_run_i && dom_run_tx_i) ? W_MAJ : '0);
    rec_step = ((rx_err_i && !flag_bit_err_i) ? W_MIN : '0)
             + (rx_dom_after_flag_i ? W_MAJ : '0)
             + ((flag_bit_err_i && !flag_bit_err_tx_i) ? W_MAJ : '0)
             + ((dom_run_i && !dom_run_tx_i) ? W_MAJ : '0);
  end

  can_fc_accum #(.PEND_W(PEND_W)) u_tec_acc (
    .clk_i, .rst_ni, .step_i(tec_step), .commit_i(delim_i), .total_o(tec_tot)
  );
  can_fc_accum #(.PEND_W(PEND_W)) u_rec_acc (
    .clk_i, .rst_ni, .step_i(rec_step), .commit_i(delim_i), .total_o(rec_tot)
  );

  can_fc_tec #(.TEC_W(TEC_W), .PEND_W(PEND_W)) u_tec (
    .clk_i, .rst_ni, .commit_i(delim_i), .inc_i(tec_tot), .ok_i(tx_ok_i),
    .tec_o, .bus_off_o(bo)
  );
  can_fc_rec #(.REC_W(REC_W), .PEND_W(PEND_W), .RELOAD(REC_RELOAD)) u_rec (
    .clk_i, .rst_ni, .commit_i(delim_i), .inc_i(rec_tot), .ok_i(rx_ok_i),
    .rec_o, .passive_o(rec_passive_o)
  );

  always_comb begin
    if (bo)                                 st = FC_BUSOFF;
    else if (tec_o >= TEC_PAS || rec_passive_o) st = FC_PASSIVE;
    else                                    st = FC_ACTIVE;
  end

  assign err_active_o  = (st == FC_ACTIVE);
  assign err_passive_o = (st == FC_PASSIVE);
  assign bus_off_o     = (st == FC_BUSOFF);

  assert_busoff_sticky_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_off_o |=> bus_off_o && $stable(tec_o));
  assert_status_onehot_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({err_active_o, err_passive_o, bus_off_o}) == 1);
endmodule

// File: tb/can_fc_top_tb.sv
`timescale 1ns/1ps
module can_fc_top_tb;
  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic rx_err_i, rx_dom_after_flag_i, tx_flag_sent_i, ack_exc_i, stuff_exc_i;
  logic flag_bit_err_i, flag_bit_err_tx_i, dom_run_i, dom_run_tx_i;
  logic tx_ok_i, rx_ok_i, delim_i;
  logic [7:0] tec_o;
  logic [6:0] rec_o;
  logic rec_passive_o, err_active_o, err_passive_o, bus_off_o;

  int checks = 0, failures = 0;
  string cur_req = "R1";
  int m_tec = 0, m_rec = 0, m_pt = 0, m_pr = 0;
  bit m_rp = 0, m_bo = 0;

  always #2 clk_i = ~clk_i;

  can_fc_top u_dut (.*);

  task automatic chk(string req, int got, int exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s got=%0d exp=%0d at %0t", req, got, exp, $time);
    end
  endtask

  // reference model, one step per rising edge
  always @(posedge clk_i) begin
    int ts, rs;
    if (!rst_ni) begin
      m_tec = 0; m_rec = 0; m_pt = 0; m_pr = 0; m_rp = 0; m_bo = 0;
    end else begin
      ts = 0; rs = 0;
      if (tx_flag_sent_i && !ack_exc_i && !stuff_exc_i) ts += 8;
      if (flag_bit_err_i) begin if (flag_bit_err_tx_i) ts += 8; else rs += 8; end
      if (dom_run_i) begin if (dom_run_tx_i) ts += 8; else rs += 8; end
      if (rx_err_i && !flag_bit_err_i) rs += 1;
      if (rx_dom_after_flag_i) rs += 8;
      m_pt += ts; m_pr += rs;
      if (delim_i) begin
        if (!m_bo) begin
          if (m_tec + m_pt > 255) begin m_tec = 255; m_bo = 1; end
          else m_tec += m_pt;
        end
        if (m_rec + m_pr > 127) begin m_rec = 127; m_rp = 1; end
        else m_rec += m_pr;
        m_pt = 0; m_pr = 0;
      end else begin
        if (tx_ok_i && !m_bo && m_tec > 0) m_tec--;
        if (rx_ok_i) begin
          if (m_rp) begin m_rec = 119; m_rp = 0; end
          else if (m_rec > 0) m_rec--;
        end
      end
    end
    #1;
    chk({cur_req, " tec"}, tec_o, m_tec);
    chk({cur_req, " rec"}, rec_o, m_rec);
    chk({cur_req, " rec_passive"}, rec_passive_o, m_rp);
    chk({cur_req, " bus_off"}, bus_off_o, m_bo);
    chk({cur_req, " err_passive"}, err_passive_o, !m_bo && (m_tec >= 128 || m_rp));
    chk({cur_req, " err_active"}, err_active_o, !m_bo && m_tec < 128 && !m_rp);
  end

  task automatic clr();
    {rx_err_i, rx_dom_after_flag_i, tx_flag_sent_i, ack_exc_i, stuff_exc_i,
     flag_bit_err_i, flag_bit_err_tx_i, dom_run_i, dom_run_tx_i,
     tx_ok_i, rx_ok_i, delim_i} = '0;
  endtask

  task automatic fire();
    @(negedge clk_i);
    clr();
  endtask

  initial begin
    clr();
    repeat (3) @(negedge clk_i);
    cur_req = "R1";
    chk("R1 tec", tec_o, 0); chk("R1 rec", rec_o, 0); chk("R1 active", err_active_o, 1);
    rst_ni = 1'b1;
    @(negedge clk_i);

    cur_req = "R2";
    tx_flag_sent_i = 1; fire();
    chk("R2 tec before delim", tec_o, 0);
    delim_i = 1; fire();
    chk("R4 flag sent", tec_o, 8);

    rx_err_i = 1; delim_i = 1; fire();
    chk("R2 same-cycle commit", rec_o, 1);

    cur_req = "R3";
    rx_dom_after_flag_i = 1; fire();
    flag_bit_err_i = 1; rx_err_i = 1; fire();
    dom_run_i = 1; fire();
    chk("R3 held", rec_o, 1);
    delim_i = 1; fire();
    chk("R3 R6 rec sum", rec_o, 25);

    cur_req = "R5";
    tx_flag_sent_i = 1; ack_exc_i = 1; delim_i = 1; fire();
    chk("R5 ack exception", tec_o, 8);
    tx_flag_sent_i = 1; stuff_exc_i = 1; delim_i = 1; fire();
    chk("R5 stuff exception", tec_o, 8);

    cur_req = "R4";
    flag_bit_err_i = 1; flag_bit_err_tx_i = 1; dom_run_i = 1; dom_run_tx_i = 1; fire();
    delim_i = 1; fire();
    chk("R4 R6 tec sum", tec_o, 24);
    chk("R4 rec untouched", rec_o, 25);

    cur_req = "R7";
    tx_ok_i = 1; fire();
    chk("R7 tx ok", tec_o, 23);
    cur_req = "R8";
    rx_ok_i = 1; fire();
    chk("R8 rx ok", rec_o, 24);

    cur_req = "R13";
    tx_flag_sent_i = 1; fire();
    tx_ok_i = 1; rx_ok_i = 1; delim_i = 1; fire();
    chk("R13 tec", tec_o, 31);
    chk("R13 rec", rec_o, 24);

    cur_req = "R9";
    for (int i = 0; i < 13; i++) begin rx_dom_after_flag_i = 1; fire(); end
    delim_i = 1; fire();
    chk("R9 rec sat", rec_o, 127);
    chk("R9 flag", rec_passive_o, 1);
    chk("R11 passive by rec", err_passive_o, 1);

    cur_req = "R10";
    rx_ok_i = 1; fire();
    chk("R10 reload", rec_o, 119);
    chk("R10 flag clr", rec_passive_o, 0);
    chk("R11 active again", err_active_o, 1);

    cur_req = "R11";
    for (int i = 0; i < 13; i++) begin tx_flag_sent_i = 1; fire(); end
    delim_i = 1; fire();
    chk("R11 tec", tec_o, 135);
    chk("R11 passive by tec", err_passive_o, 1);

    cur_req = "R12";
    for (int i = 0; i < 15; i++) begin tx_flag_sent_i = 1; fire(); end
    delim_i = 1; fire();
    chk("R12 exact 255", tec_o, 255);
    chk("R12 not bus-off", bus_off_o, 0);
    tx_flag_sent_i = 1; delim_i = 1; fire();
    chk("R12 bus-off", bus_off_o, 1);
    chk("R12 tec sat", tec_o, 255);
    tx_ok_i = 1; fire();
    chk("R12 frozen", tec_o, 255);
    chk("R11 only bus-off", err_passive_o + err_active_o, 0);

    cur_req = "R1";
    rst_ni = 1'b0; @(negedge clk_i);
    chk("R1 reset tec", tec_o, 0); chk("R1 reset bo", bus_off_o, 0);
    rst_ni = 1'b1; @(negedge clk_i);

    cur_req = "R8";
    rx_ok_i = 1; tx_ok_i = 1; fire();
    chk("R8 floor", rec_o, 0);
    chk("R7 floor", tec_o, 0);
    repeat (2) @(negedge clk_i);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    failures++;
    $display("FAIL watchdog got=hung exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule